// File: doc/BRIEF.md
# Paged Edge-Detect Digital I/O Controller

This block sits on a byte-wide host register bus and controls 48 general-purpose lines, grouped as six 8-bit ports. The host writes a port register to pull lines low and reads it to sample the pads. Both directions are active-low: a 1 means "low". The lines are treated as open-drain: the block drives only the pull-low enables, and the pad level comes back through a two-flop synchronizer.

The 24 lines of ports 0 to 2 can raise an interrupt. For each of these lines, software picks the edge direction and an enable. An edge that matches latches into an identification bit, which stays set until software writes 1 to it. A summary register shows which of the three ports has a latched edge, and a single active-high interrupt output is the OR of all latched edges.

Only a 4-bit address space is used. Addresses 8 to 10 are shared by three register sets: polarity, enable and identification. The page field of a page/lock register picks which set answers there. The same page/lock register also holds one write-protect bit per port.

Top module: `pagedEdgeGpio`

## Requirements
- R1: After reset, every line is released (`lineDrvLow` all 0), `irq` is low, and the pending summary reads 0. Reset also clears the page, the locks, and all polarity, enable and ID bits.
- R2: A write to address p (0..5) of an unlocked port stores the byte. The next clock drives low each line whose written bit is 1: bit b of port p is line 8p+b.
- R3: A read of address p (0..5) returns, for each bit, 1 when the synchronized pad is low. The value is the pad as sampled two clocks earlier.
- R4: Address 7 is write-only. Bits 7:6 hold the page and bits 5:0 lock ports 5..0. A write to a locked port leaves its drive unchanged.
- R5: With page 1, addresses 8..10 write the polarity of ports 0..2. A 1 selects a rising pad edge and a 0 selects a falling pad edge. An edge in the other direction is not latched.
- R6: With page 2, addresses 8..10 write the enables of ports 0..2. A line whose enable is 0 never sets its ID bit.
- R7: With page 3, addresses 8..10 read the ID bits of ports 0..2. A qualifying pad change shows up in the ID bit on the third clock after it. Writing 1 to an ID bit clears it, and writing 0 leaves it unchanged.
- R8: Address 6 reads the pending summary on every page. Bit q is 1 when port q has any ID bit set, and bits 7:3 read 0.
- R9: `irq` is high exactly when any ID bit is set.
- R10: Pad edges on ports 3..5 never set pending bits or `irq`.
- R11: With page 0, addresses 8..10 read 0 and writes to them change nothing. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address |
| busWr | input | 1 | Write strobe, one clock per write |
| busRd | input | 1 | Read strobe; read data is combinational while it is high |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, 0 when no readable register is addressed |
| padIn | input | 48 | Pad levels of the 48 lines |
| lineDrvLow | output | 48 | Pull-low enable per line |
| irq | output | 1 | Active-high interrupt, OR of all ID bits |

## Verification
Read data is due in the same cycle as the read strobe. A port write reaches `lineDrvLow` after one clock. A pad change reaches a port read after two clocks and an ID bit or `irq` after three, and a clearing write takes effect after one. The bench feeds the same stimulus into a behavioural model that keeps a three-deep sample history of the pads. It compares drive, interrupt and read data with the model at every falling edge, after the rising edge that changes them and before new inputs are applied. The directed checks wait exactly those clock counts before sampling.

// File: rtl/gpioPagedPkg.sv
package gpioPagedPkg;
  parameter int ADDR_W     = 4;
  parameter int PORT_W     = 8;
  parameter int NUM_PORTS  = 6;
  parameter int IRQ_PORTS  = 3;
  parameter int LINES      = NUM_PORTS * PORT_W;
  parameter int IRQ_LINES  = IRQ_PORTS * PORT_W;
  parameter int IDX_W      = 3;
  parameter int PAGE_W     = 2;
  parameter int PEND_ADDR  = 6;
  parameter int PAGE_ADDR  = 7;
  parameter int PAGED_BASE = 8;
  parameter int PAGE_POL   = 1;
  parameter int PAGE_EN    = 2;
  parameter int PAGE_ID    = 3;

  typedef enum logic [1:0] {RD_NONE, RD_PORT, RD_PEND, RD_ID} rdSelE;

  typedef struct packed {
    logic [NUM_PORTS-1:0] portWr;
    logic [IRQ_PORTS-1:0] polWr;
    logic [IRQ_PORTS-1:0] enWr;
    logic [IRQ_PORTS-1:0] idClr;
    logic [PORT_W-1:0]    wdata;
    rdSelE                rdSel;
    logic [IDX_W-1:0]     rdIdx;
  } strobeT;
endpackage

// File: rtl/gpioPageCtrl.sv
module gpioPageCtrl
  import gpioPagedPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PORT_W-1:0] busWdata,
  output strobeT            strobe,
  output logic [NUM_PORTS-1:0] lockBits,
  output logic [PAGE_W-1:0] pageSel
);
  localparam logic [ADDR_W-1:0] PAGE_A  = ADDR_W'(PAGE_ADDR);
  localparam logic [ADDR_W-1:0] PEND_A  = ADDR_W'(PEND_ADDR);
  localparam logic [ADDR_W-1:0] PAGED_A = ADDR_W'(PAGED_BASE);
  localparam logic [ADDR_W-1:0] PORTS_A = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] PAGED_END = ADDR_W'(PAGED_BASE + IRQ_PORTS);

  logic             isPort;
  logic             isPaged;
  logic [IDX_W-1:0] portIdx;
  logic [IDX_W-1:0] pagedIdx;

  // page / lock register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageSel  <= '0;
      lockBits <= '0;
    end else if (busWr && busAddr == PAGE_A) begin
      pageSel  <= busWdata[PORT_W-1 -: PAGE_W];
      lockBits <= busWdata[NUM_PORTS-1:0];
    end
  end

  always_comb begin
    isPort   = busAddr < PORTS_A;
    isPaged  = (busAddr >= PAGED_A) && (busAddr < PAGED_END);
    portIdx  = busAddr[IDX_W-1:0];
    pagedIdx = IDX_W'(busAddr - PAGED_A);

    strobe       = '0;
    strobe.wdata = busWdata;
    strobe.rdSel = RD_NONE;

    for (int p = 0; p < NUM_PORTS; p++) begin
      strobe.portWr[p] = busWr && isPort && (portIdx == IDX_W'(p)) && !lockBits[p];
    end

    for (int q = 0; q < IRQ_PORTS; q++) begin
      if (busWr && isPaged && (pagedIdx == IDX_W'(q))) begin
        strobe.polWr[q] = (pageSel == PAGE_W'(PAGE_POL));
        strobe.enWr[q]  = (pageSel == PAGE_W'(PAGE_EN));
        strobe.idClr[q] = (pageSel == PAGE_W'(PAGE_ID));
      end
    end

    if (busRd) begin
      if (isPort) begin
        strobe.rdSel = RD_PORT;
        strobe.rdIdx = portIdx;
      end else if (busAddr == PEND_A) begin
        strobe.rdSel = RD_PEND;
      end else if (isPaged && pageSel == PAGE_W'(PAGE_ID)) begin
        strobe.rdSel = RD_ID;
        strobe.rdIdx = pagedIdx;
      end
    end
  end
endmodule

// File: rtl/gpioEdgeDatapath.sv
module gpioEdgeDatapath
  import gpioPagedPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [LINES-1:0]  padIn,
  output logic [LINES-1:0]  lineDrvLow,
  output logic [PORT_W-1:0] rdData,
  output logic              irq,
  output logic [IRQ_LINES-1:0] idBits,
  output logic [IRQ_LINES-1:0] enBits
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PORTS-1:0][PORT_W-1:0] portQ;
  logic [SYNC_STAGES-1:0][LINES-1:0] syncQ;
  logic [LINES-1:0] prevQ;
  logic [NUM_PORTS-1:0][PORT_W-1:0] lineBytes;
  logic [NUM_PORTS-1:0][PORT_W-1:0] prevBytes;
  logic [IRQ_PORTS-1:0][PORT_W-1:0] polQ;
  logic [IRQ_PORTS-1:0][PORT_W-1:0] enQ;
  logic [IRQ_PORTS-1:0][PORT_W-1:0] idQ;
  logic [IRQ_PORTS-1:0][PORT_W-1:0] idNext;
  logic [IRQ_PORTS-1:0] pending;

  assign lineDrvLow = portQ;
  assign lineBytes  = syncQ[LAST];
  assign prevBytes  = prevQ;
  assign idBits     = idQ;
  assign enBits     = enQ;

  // port drive registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portQ <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobe.portWr[p]) portQ[p] <= strobe.wdata;
      end
    end
  end

  // input synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  // per interrupt-capable port: polarity, enable, edge latch
  for (genvar q = 0; q < IRQ_PORTS; q++) begin : g_irqPort
    logic [PORT_W-1:0] riseV;
    logic [PORT_W-1:0] fallV;
    logic [PORT_W-1:0] hitV;
    logic [PORT_W-1:0] clrV;

    assign riseV = lineBytes[q] & ~prevBytes[q];
    assign fallV = ~lineBytes[q] & prevBytes[q];
    assign hitV  = enQ[q] & ((polQ[q] & riseV) | (~polQ[q] & fallV));
    assign clrV  = strobe.idClr[q] ? strobe.wdata : '0;
    assign idNext[q]  = (idQ[q] & ~clrV) | hitV;
    assign pending[q] = |idQ[q];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        polQ[q] <= '0;
        enQ[q]  <= '0;
        idQ[q]  <= '0;
      end else begin
        if (strobe.polWr[q]) polQ[q] <= strobe.wdata;
        if (strobe.enWr[q])  enQ[q]  <= strobe.wdata;
        idQ[q] <= idNext[q];
      end
    end
  end

  assign irq = |pending;

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_PORT: rdData = ~lineBytes[strobe.rdIdx];
      RD_PEND: rdData = PORT_W'(pending);
      RD_ID:   rdData = idQ[strobe.rdIdx];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pagedEdgeGpio.sv
module pagedEdgeGpio
  import gpioPagedPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [LINES-1:0]  padIn,
  output logic [LINES-1:0]  lineDrvLow,
  output logic              irq
);
  strobeT strobe;
  logic [NUM_PORTS-1:0] lockBits;
  logic [PAGE_W-1:0]    pageSel;
  logic [IRQ_LINES-1:0] idBits;
  logic [IRQ_LINES-1:0] enBits;

  gpioPageCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .strobe   (strobe),
    .lockBits (lockBits),
    .pageSel  (pageSel)
  );

  gpioEdgeDatapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .padIn      (padIn),
    .lineDrvLow (lineDrvLow),
    .rdData     (busRdata),
    .irq        (irq),
    .idBits     (idBits),
    .enBits     (enBits)
  );
endmodule

// File: rtl/gpioPagedChecker.sv
module gpioPagedChecker
  import gpioPagedPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [PORT_W-1:0] busWdata,
  input logic [PORT_W-1:0] busRdata,
  input logic [LINES-1:0]  lineDrvLow,
  input logic              irq,
  input logic [NUM_PORTS-1:0] lockBits,
  input logic [PAGE_W-1:0] pageSel,
  input logic [IRQ_LINES-1:0] idBits,
  input logic [IRQ_LINES-1:0] enBits
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assert_port_write_R2: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ADDR_W'(p) && !lockBits[p])
        |=> lineDrvLow[p*PORT_W +: PORT_W] == $past(busWdata))
      else $error("port write not applied");

    assert_locked_port_R4: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ADDR_W'(p) && lockBits[p])
        |=> $stable(lineDrvLow[p*PORT_W +: PORT_W]))
      else $error("locked port changed");
  end

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (idBits & ~$past(idBits) & ~$past(enBits)) == '0)
    else $error("disabled line latched an edge");

  assert_id_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(idBits) & ~idBits) != '0)
      |-> $past(busWr && pageSel == PAGE_W'(PAGE_ID)
                && busAddr >= ADDR_W'(PAGED_BASE)
                && busAddr < ADDR_W'(PAGED_BASE + IRQ_PORTS)))
    else $error("ID bit dropped without a clearing write");

  assert_pend_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(PEND_ADDR)) |-> busRdata[PORT_W-1:IRQ_PORTS] == '0)
    else $error("pending upper bits nonzero");

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    (idBits != '0) |-> irq)
    else $error("latched edge without interrupt");

  assert_page0_blank_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && pageSel == '0 && busAddr >= ADDR_W'(PAGED_BASE)) |-> busRdata == '0)
    else $error("page 0 paged read nonzero");
endmodule

bind pagedEdgeGpio gpioPagedChecker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWr      (busWr),
  .busRd      (busRd),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .lineDrvLow (lineDrvLow),
  .irq        (irq),
  .lockBits   (lockBits),
  .pageSel    (pageSel),
  .idBits     (idBits),
  .enBits     (enBits)
);

// File: tb/pagedEdgeGpio_test.sv
module pagedEdgeGpio_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [47:0] extLevel = '1;
  logic [47:0] padIn;
  logic [47:0] lineDrvLow;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  // open-drain line: low when the outside pulls it or the block drives it
  assign padIn = extLevel & ~lineDrvLow;

  pagedEdgeGpio uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .lineDrvLow(lineDrvLow), .irq(irq)
  );

  // behavioural reference model
  logic [47:0] mDrv = '0, ms1 = '0, ms2 = '0, ms3 = '0;
  logic [1:0]  mPage = '0;
  logic [5:0]  mLock = '0;
  logic [23:0] mPol = '0, mEn = '0, mId = '0;
  logic [23:0] tRise, tFall, tHit, tClr;

  always @(posedge clk) begin
    if (!rstN) begin
      mDrv = '0; ms1 = '0; ms2 = '0; ms3 = '0;
      mPage = '0; mLock = '0; mPol = '0; mEn = '0; mId = '0;
    end else begin
      tRise = ms2[23:0] & ~ms3[23:0];
      tFall = ~ms2[23:0] & ms3[23:0];
      tHit  = mEn & ((mPol & tRise) | (~mPol & tFall));
      tClr  = '0;
      if (busWr && busAddr >= 8 && busAddr <= 10 && mPage == 3)
        tClr[(busAddr - 8) * 8 +: 8] = busWdata;
      mId = (mId & ~tClr) | tHit;
      if (busWr) begin
        if (busAddr < 6) begin
          if (!mLock[busAddr]) mDrv[busAddr * 8 +: 8] = busWdata;
        end else if (busAddr == 7) begin
          mPage = busWdata[7:6];
          mLock = busWdata[5:0];
        end else if (busAddr >= 8 && busAddr <= 10) begin
          if (mPage == 1) mPol[(busAddr - 8) * 8 +: 8] = busWdata;
          if (mPage == 2) mEn[(busAddr - 8) * 8 +: 8] = busWdata;
        end
      end
      ms3 = ms2; ms2 = ms1; ms1 = padIn;
    end
  end

  function automatic logic [7:0] expRead();
    logic [7:0] v;
    v = '0;
    if (busRd) begin
      if (busAddr < 6) v = ~ms2[busAddr * 8 +: 8];
      else if (busAddr == 6) v = {5'b0, |mId[23:16], |mId[15:8], |mId[7:0]};
      else if (busAddr >= 8 && busAddr <= 10 && mPage == 3) v = mId[(busAddr - 8) * 8 +: 8];
    end
    return v;
  endfunction

  task automatic checkEq(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    checkEq("R2/R4 drive vs model", lineDrvLow, mDrv);
    checkEq("R9 irq vs model", {47'b0, irq}, {47'b0, (mId != 0)});
    checkEq("R3/R7/R8/R11 read vs model", {40'b0, busRdata}, {40'b0, expRead()});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (running) compareAll();
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    tick(1);
    busWr = 1'b0;
  endtask

  task automatic readCheck(input logic [3:0] a, input logic [7:0] exp, input string tag);
    busAddr = a; busRd = 1'b1;
    #1;
    checkEq(tag, {40'b0, busRdata}, {40'b0, exp});
    tick(1);
    busRd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    tick(3);
    // R1 reset state
    checkEq("R1 drive after reset", lineDrvLow, 48'h0);
    checkEq("R1 irq after reset", {47'b0, irq}, 48'h0);
    readCheck(4'd6, 8'h00, "R1 pending after reset");

    // R2 / R3 inverted drive and readback
    busWrite(4'd0, 8'hA5);
    checkEq("R2 port0 drive", lineDrvLow[7:0], 48'hA5);
    tick(2);
    readCheck(4'd0, 8'hA5, "R3 port0 readback low lines");
    extLevel[40] = 1'b0;
    tick(2);
    readCheck(4'd5, 8'h01, "R3 external low on port5");

    // R4 lock
    busWrite(4'd7, 8'h02);
    busWrite(4'd1, 8'hFF);
    checkEq("R4 locked port1 unchanged", lineDrvLow[15:8], 48'h0);
    busWrite(4'd2, 8'h3C);
    checkEq("R4 unlocked port2 written", lineDrvLow[23:16], 48'h3C);
    busWrite(4'd0, 8'h00);
    busWrite(4'd2, 8'h00);
    tick(3);

    // polarity and enables
    busWrite(4'd7, 8'h42);
    busWrite(4'd8, 8'h01);
    busWrite(4'd7, 8'h82);
    busWrite(4'd8, 8'h05);
    busWrite(4'd9, 8'h02);
    busWrite(4'd7, 8'hC2);
    extLevel[0] = 1'b0;
    tick(3);
    readCheck(4'd8, 8'h00, "R5 falling edge on rising-polarity line");
    extLevel[0] = 1'b1;
    tick(3);
    readCheck(4'd8, 8'h01, "R5 R7 rising edge latched");
    extLevel[3] = 1'b0;
    tick(3);
    extLevel[3] = 1'b1;
    tick(3);
    readCheck(4'd8, 8'h01, "R6 disabled line not latched");
    readCheck(4'd6, 8'h01, "R8 pending port0");
    checkEq("R9 irq high", {47'b0, irq}, 48'h1);
    extLevel[9] = 1'b0;
    tick(3);
    readCheck(4'd9, 8'h02, "R5 falling edge latched");
    readCheck(4'd6, 8'h03, "R8 pending ports 0 and 1");

    // R7 clear
    busWrite(4'd8, 8'h01);
    readCheck(4'd8, 8'h00, "R7 write-one clear");
    checkEq("R9 irq held by port1", {47'b0, irq}, 48'h1);
    busWrite(4'd9, 8'h00);
    readCheck(4'd9, 8'h02, "R7 write-zero keeps bit");
    busWrite(4'd9, 8'h02);
    checkEq("R9 irq low after clear", {47'b0, irq}, 48'h0);

    // R10 ports 3..5 never interrupt
    extLevel[24] = 1'b0;
    extLevel[47] = 1'b0;
    tick(4);
    readCheck(4'd6, 8'h00, "R10 no pending from port3/5");
    checkEq("R10 irq low", {47'b0, irq}, 48'h0);

    // R11 page 0 blank window
    busWrite(4'd7, 8'h02);
    readCheck(4'd8, 8'h00, "R11 page0 paged read");
    readCheck(4'd7, 8'h00, "R11 page register reads zero");
    busWrite(4'd8, 8'h00);
    busWrite(4'd7, 8'hC2);
    extLevel[2] = 1'b0;
    tick(3);
    readCheck(4'd8, 8'h04, "R11 page0 write left enable intact");

    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule